// File: doc/BRIEF.md
# Multi-Channel Input Timestamp Capture

This block watches a set of asynchronous digital inputs and records the moment each one goes high. Every rising edge, after the input has been synchronized, stores the current timebase value in a queue belonging to that channel. The stored value is a seconds count plus a sub-second cycle count, one cycle being 16 ns. Capture runs on every channel at all times, whatever the surrounding logic does with the pin.

Software drains a channel through one small read port. A channel select and a register select pick one 32-bit word: the low seconds word, the upper seconds bits, the cycle count or a status word. Reading the cycle count removes the entry, so the two seconds words must be read first. Each channel shows a pending flag while its queue holds data, and the block raises one level interrupt request while any channel is pending. A full queue drops new events and records the loss in a sticky overflow flag. Reading the channel's status word clears that flag.

Top module: `tstamp_capture`

## Requirements
- R1: During and after reset `rd_data_o`, `pend_o`, `ovf_o` and `irq_o` are all zero and every queue is empty.
- R2: When `sig_i[c]` is first seen high at clock edge k, channel c stores `{sec_i, cyc_i}` as sampled at edge k+2. Two synchronizer flops and one edge-detect flop lie on this path.
- R3: One capture is made per high period, however long the input stays high. A low level seen at one clock edge or more re-arms the channel.
- R4: A read is requested with `rd_en_i`. Its word appears on `rd_data_o` one cycle later and is held until the next read. `rd_sel_i` picks the word: 0 gives seconds bits 31:0, 1 gives seconds bits 39:32 in bits 7:0, 2 gives the 28-bit cycle count in bits 27:0, and 3 gives status (fill level in bits 8:0, overflow flag in bit 9). All other bits read as zero.
- R5: A read with select 2 removes the oldest entry of a non-empty channel. Reads with selects 0, 1 and 3 never remove an entry.
- R6: A read with select 0, 1 or 2 on an empty channel returns zero and leaves the queue unchanged.
- R7: Each channel keeps its own queue in arrival order. Events on one channel never appear in, or affect, another channel's queue.
- R8: Each queue holds 256 entries. An event arriving at a full queue is dropped, even if a removal happens in the same cycle, and it sets the channel's `ovf_o` bit. That bit stays set until a status read of that channel, which returns the flag still set and then clears it. A drop in the same cycle as the clear wins.
- R9: `pend_o[c]` is high exactly while channel c holds an entry, starting the cycle after the capture edge. `irq_o` is high exactly while any `pend_o` bit is high.
- R10: A read of channel number 5, 6 or 7 returns zero and changes no queue or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock, one cycle per 16 ns tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sig_i | input | 5 | Asynchronous event inputs, one per channel |
| sec_i | input | 40 | Current seconds count from the timebase |
| cyc_i | input | 28 | Current sub-second cycle count from the timebase |
| rd_en_i | input | 1 | Read strobe, one word per asserted cycle |
| rd_ch_i | input | 3 | Channel number for the read |
| rd_sel_i | input | 2 | Word select: 0 seconds low, 1 seconds high, 2 cycles (removes entry), 3 status |
| rd_data_o | output | 32 | Registered read data |
| pend_o | output | 5 | Per-channel queue-not-empty flags |
| ovf_o | output | 5 | Per-channel sticky overflow flags |
| irq_o | output | 1 | Level interrupt request, any channel pending |

## Verification
The checker covers several properties on every cycle. A fill level never goes past 256, and a full queue stays full when an event arrives without a removal. Two captures never happen on back-to-back cycles of one channel. A pending flag only drops after a cycle-count read of that channel, and an overflow flag only drops after a status read. Reads of an empty or nonexistent channel return zero. The exact tag values, the two-edge capture latency, the per-channel ordering and the status contents around the overflow point depend on long stimulus histories. Only the bench's scenarios, checked against its behavioural queue model, can show those.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int RD_W = 32;

  typedef enum logic [1:0] {
    SEL_SEC_LO = 2'd0,
    SEL_SEC_HI = 2'd1,
    SEL_CYC    = 2'd2,
    SEL_STAT   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/tsc_sync_edge.sv
module tsc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], sig_i};
    prev_d = sync_q[STAGES-1];
    rise_o = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/tsc_fifo.sv
module tsc_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 68,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  input  logic          clr_ovf_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, empty, wr_ok, pop_ok, drop;

  always_comb begin
    full   = (cnt_q == CW'(DEPTH));
    empty  = (cnt_q == '0);
    wr_ok  = wr_i & ~full;
    drop   = wr_i & full;
    pop_ok = pop_i & ~empty;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_ok)  wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + AW'(1);
    if (pop_ok) rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + AW'(1);
    cnt_d  = cnt_q + CW'(wr_ok) - CW'(pop_ok);
    ovf_d  = (ovf_q & ~clr_ovf_i) | drop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wdata_i;
  end

  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import tsc_pkg::*;
#(
  parameter int NCH         = 5,
  parameter int DEPTH       = 256,
  parameter int SEC_W       = 40,
  parameter int CYC_W       = 28,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ENT_W      = SEC_W + CYC_W,
  localparam int CNT_W      = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   sig_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             rd_en_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  input  logic [1:0]       rd_sel_i,
  output logic [RD_W-1:0]  rd_data_o,
  output logic [NCH-1:0]   pend_o,
  output logic [NCH-1:0]   ovf_o,
  output logic             irq_o
);
  logic [NCH-1:0]             rise_w, pop_w, clr_w;
  logic [NCH-1:0][ENT_W-1:0]  head_w;
  logic [NCH-1:0][CNT_W-1:0]  cnt_w;
  logic [ENT_W-1:0]           stamp;
  logic [ENT_W-1:0]           head_sel;
  logic [CNT_W-1:0]           cnt_sel;
  logic                       ovf_sel, empty_sel;
  logic [RD_W-1:0]            rdata_q, rdata_d;
  rd_sel_e                    sel;

  assign stamp = {sec_i, cyc_i};
  assign sel   = rd_sel_e'(rd_sel_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tsc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (sig_i[c]),
      .rise_o (rise_w[c])
    );

    assign pop_w[c] = rd_en_i & (sel == SEL_CYC)  & (int'(rd_ch_i) == c);
    assign clr_w[c] = rd_en_i & (sel == SEL_STAT) & (int'(rd_ch_i) == c);

    tsc_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (rise_w[c]),
      .wdata_i   (stamp),
      .pop_i     (pop_w[c]),
      .clr_ovf_i (clr_w[c]),
      .head_o    (head_w[c]),
      .count_o   (cnt_w[c]),
      .ovf_o     (ovf_o[c])
    );

    assign pend_o[c] = (cnt_w[c] != '0);
  end

  assign irq_o = |pend_o;

  always_comb begin
    head_sel  = '0;
    cnt_sel   = '0;
    ovf_sel   = 1'b0;
    empty_sel = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (int'(rd_ch_i) == c) begin
        head_sel  = head_w[c];
        cnt_sel   = cnt_w[c];
        ovf_sel   = ovf_o[c];
        empty_sel = ~pend_o[c];
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en_i) begin
      unique case (sel)
        SEL_SEC_LO: rdata_d = empty_sel ? '0 : head_sel[CYC_W +: 32];
        SEL_SEC_HI: rdata_d = empty_sel ? '0 : RD_W'(head_sel[ENT_W-1:CYC_W+32]);
        SEL_CYC:    rdata_d = empty_sel ? '0 : RD_W'(head_sel[CYC_W-1:0]);
        SEL_STAT:   rdata_d = RD_W'({ovf_sel, cnt_sel});
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rd_data_o = rdata_q;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int NCH   = 5,
  parameter int DEPTH = 256,
  parameter int CH_W  = 3,
  parameter int CNT_W = 9
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      rd_en_i,
  input logic [CH_W-1:0]           rd_ch_i,
  input logic [1:0]                rd_sel_i,
  input logic [31:0]               rd_data_o,
  input logic [NCH-1:0]            pend_o,
  input logic [NCH-1:0]            ovf_o,
  input logic [NCH-1:0]            rise_w,
  input logic [NCH-1:0][CNT_W-1:0] cnt_w
);
  logic ch_valid, ch_empty;
  assign ch_valid = (int'(rd_ch_i) < NCH);
  assign ch_empty = (((pend_o >> rd_ch_i) & NCH'(1)) == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic pop_req, stat_req;
    assign pop_req  = rd_en_i && rd_sel_i == 2'd2 && int'(rd_ch_i) == c;
    assign stat_req = rd_en_i && rd_sel_i == 2'd3 && int'(rd_ch_i) == c;

    AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_w[c] <= CNT_W'(DEPTH));                                         // R8
    AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_w[c] == CNT_W'(DEPTH) && rise_w[c] && !pop_req) |=> (cnt_w[c] == CNT_W'(DEPTH) && ovf_o[c])); // R8
    AST_ONE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_w[c] |=> !rise_w[c]);                                          // R3
    AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[c] && !pop_req) |=> pend_o[c]);                             // R5
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o[c] && !stat_req) |=> ovf_o[c]);                              // R8
  end

  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i != 2'd3 && ch_valid && ch_empty) |=> rd_data_o == '0); // R6
  AST_BAD_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !ch_valid) |=> rd_data_o == '0);                           // R10
endmodule

bind tstamp_capture tsc_checker #(
  .NCH(NCH), .DEPTH(DEPTH), .CH_W(CH_W), .CNT_W(CNT_W)
) u_tsc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_i   (rd_en_i),
  .rd_ch_i   (rd_ch_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .pend_o    (pend_o),
  .ovf_o     (ovf_o),
  .rise_w    (rise_w),
  .cnt_w     (cnt_w)
);

// File: tb/tstamp_capture_test.sv
`timescale 1ns/1ps
module tstamp_capture_test;
  localparam logic [39:0] SEC_BASE = 40'hA5_0000_0F00;

  logic        clk;
  logic        rst_n;
  logic [4:0]  sig_i;
  logic [39:0] sec_i;
  logic [27:0] cyc_i;
  logic        rd_en_i;
  logic [2:0]  rd_ch_i;
  logic [1:0]  rd_sel_i;
  logic [31:0] rd_data_o;
  logic [4:0]  pend_o, ovf_o;
  logic        irq_o;

  tstamp_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig_i), .sec_i(sec_i), .cyc_i(cyc_i),
    .rd_en_i(rd_en_i), .rd_ch_i(rd_ch_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .pend_o(pend_o), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nvec = 0, nfail = 0;
  longint unsigned tick = 0;
  logic [4:0] cur_sig = '0;

  // reference model state
  logic [67:0] mq [5][$];
  bit   [4:0]  m_ovf = '0;
  bit   [4:0]  m_s1 = '0, m_s2 = '0, m_pv = '0;
  logic [31:0] m_rd = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  task automatic step(input bit ren, input int ch, input int sel);
    logic [39:0] s;
    logic [27:0] cy;
    bit [4:0] rise, fullp;
    @(negedge clk);
    s  = SEC_BASE + 40'(tick);
    cy = 28'(tick);
    sig_i = cur_sig; rd_en_i = ren; rd_ch_i = 3'(ch); rd_sel_i = 2'(sel);
    sec_i = s; cyc_i = cy;
    @(posedge clk); #1;
    rise = m_s2 & ~m_pv;
    for (int c = 0; c < 5; c++) fullp[c] = (mq[c].size() == 256);
    if (ren) begin
      if (ch >= 5) m_rd = '0;
      else begin
        case (sel)
          0: m_rd = (mq[ch].size() != 0) ? mq[ch][0][59:28] : '0;
          1: m_rd = (mq[ch].size() != 0) ? 32'(mq[ch][0][67:60]) : '0;
          2: m_rd = (mq[ch].size() != 0) ? 32'(mq[ch][0][27:0]) : '0;
          default: m_rd = 32'({m_ovf[ch], 9'(mq[ch].size())});
        endcase
        if (sel == 2 && mq[ch].size() != 0) void'(mq[ch].pop_front());
        if (sel == 3) m_ovf[ch] = 1'b0;
      end
    end
    for (int c = 0; c < 5; c++) begin
      if (rise[c]) begin
        if (fullp[c]) m_ovf[c] = 1'b1;
        else mq[c].push_back({s, cy});
      end
    end
    m_pv = m_s2; m_s2 = m_s1; m_s1 = cur_sig;
    tick++;
    begin
      logic [4:0] ep;
      for (int c = 0; c < 5; c++) ep[c] = (mq[c].size() != 0);
      chk("R4 rd_data", rd_data_o, m_rd);
      chk("R9 pend", 32'(pend_o), 32'(ep));
      chk("R8 ovf", 32'(ovf_o), 32'(m_ovf));
      chk("R9 irq", 32'(irq_o), 32'(|ep));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  task automatic rd(input int ch, input int sel, output logic [31:0] d);
    step(1'b1, ch, sel);
    d = rd_data_o;
  endtask

  task automatic pulse(input int ch);
    cur_sig[ch] = 1'b1; idle(1);
    cur_sig[ch] = 1'b0; idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    longint unsigned k, k1, k2, k3;
    sig_i = '0; sec_i = '0; cyc_i = '0; rd_en_i = 1'b0; rd_ch_i = '0; rd_sel_i = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset rd_data", rd_data_o, 32'h0);
    chk("R1 reset pend", 32'(pend_o), 32'h0);
    chk("R1 reset ovf", 32'(ovf_o), 32'h0);
    chk("R1 reset irq", 32'(irq_o), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    chk("R1 empty after release", 32'(pend_o), 32'h0);

    // R2: tag value and latency
    k = tick; cur_sig[1] = 1'b1; idle(4); cur_sig[1] = 1'b0; idle(3);
    rd(1, 0, d); chk("R2 sec low", d, 32'(SEC_BASE + 40'(k + 2)));
    chk("R5 sec read keeps entry", 32'(pend_o[1]), 32'h1);
    rd(1, 1, d); chk("R2 sec high", d, 32'h0000_00A5);
    rd(1, 2, d); chk("R2 cycles", d, 32'(k + 2));
    chk("R5 cycles read pops", 32'(pend_o[1]), 32'h0);

    // R3: one capture per high period, one low edge re-arms
    cur_sig[0] = 1'b1; idle(20); cur_sig[0] = 1'b0; idle(3);
    rd(0, 3, d); chk("R3 long high gives one", d, 32'd1);
    cur_sig[0] = 1'b1; idle(3); cur_sig[0] = 1'b0; idle(1); cur_sig[0] = 1'b1; idle(4);
    cur_sig[0] = 1'b0; idle(3);
    rd(0, 3, d); chk("R3 one-cycle low rearms", d, 32'd3);

    // R6: empty channel reads
    rd(3, 0, d); chk("R6 empty sec low", d, 32'h0);
    rd(3, 2, d); chk("R6 empty cycles", d, 32'h0);
    rd(3, 3, d); chk("R6 empty status", d, 32'h0);

    // R7: independent ordered queues
    k1 = tick; pulse(4); idle(2);
    k2 = tick; pulse(2); idle(2);
    k3 = tick; pulse(4); idle(3);
    cur_sig[2] = 1'b1; cur_sig[4] = 1'b1; idle(2); cur_sig[2] = 1'b0; cur_sig[4] = 1'b0; idle(3);
    rd(4, 2, d); chk("R7 ch4 first", d, 32'(k1 + 2));
    rd(4, 2, d); chk("R7 ch4 second", d, 32'(k3 + 2));
    rd(2, 2, d); chk("R7 ch2 first", d, 32'(k2 + 2));
    rd(2, 3, d); chk("R7 ch2 level", d, 32'd1);
    rd(4, 3, d); chk("R7 ch4 level", d, 32'd1);

    // R10: nonexistent channels
    rd(6, 2, d); chk("R10 ch6 read", d, 32'h0);
    rd(5, 3, d); chk("R10 ch5 status", d, 32'h0);
    rd(0, 3, d); chk("R10 ch0 untouched", d, 32'd3);

    // R8: fill, overflow, sticky flag, clear
    for (int i = 0; i < 256; i++) pulse(3);
    idle(3);
    chk("R8 full no ovf", 32'(ovf_o[3]), 32'h0);
    pulse(3); idle(3);
    chk("R8 overflow set", 32'(ovf_o[3]), 32'h1);
    idle(5);
    chk("R8 overflow sticky", 32'(ovf_o[3]), 32'h1);
    rd(3, 3, d); chk("R8 status full+ovf", d, 32'h0000_0300);
    chk("R8 ovf cleared", 32'(ovf_o[3]), 32'h0);
    rd(3, 2, d); pulse(3); idle(3);
    rd(3, 3, d); chk("R8 refill after pop", d, 32'd256);

    // R9: drain everything, interrupt drops
    chk("R9 irq while pending", 32'(irq_o), 32'h1);
    for (int c = 0; c < 5; c++)
      while (pend_o[c]) rd(c, 2, d);
    idle(2);
    chk("R9 irq low when drained", 32'(irq_o), 32'h0);

    summary();
    $finish;
  end
endmodule